// File: doc/BRIEF.md
# Display RAM Address Counter with Line-Gap Skipping

This block holds the address counter that points into the display-data RAM of a five-line character display controller. Each line owns a window of twelve cells. The windows start sixteen addresses apart, so the address space has four-cell holes between lines and an unused region above the last line. The counter walks only through the occupied cells. After each data access it steps one place in the selected direction. At a line end it jumps to the next line, and it wraps at either end of the whole space.

Software sets the counter with two instruction bytes on an 8-bit bus. The first byte selects the line group and also latches a scan-interrupt enable and a two-bit key-format field. The second byte sets the low five address bits. While the device is in sleep or standby, these address-set bytes are refused.

Top module: `ddram_addr_ctr`

## Requirements
- R1: After reset, `addr` is 0x00, `scan_int_en` is 0 and `key_fmt` is 0.
- R2: An instruction byte whose bits [7:5] are 110 sets `addr[6:5]` from bits [1:0], `scan_int_en` from bit 4 and `key_fmt` from bits [3:2]. It leaves `addr[4:0]` unchanged.
- R3: An instruction byte whose bits [7:5] are 111 sets `addr[4:0]` from bits [4:0]. It leaves `addr[6:5]`, `scan_int_en` and `key_fmt` unchanged.
- R4: An instruction byte whose bits [7:5] are neither 110 nor 111 changes neither `addr` nor the latched control bits.
- R5: While `sleep` or `standby` is high, an instruction write changes neither `addr` nor the control latches.
- R6: With `dir_inc` high, an access strobe moves a valid address to the next valid one. The valid addresses are columns 0x0 to 0xB of lines 0 to 4, with the line in bits [6:4] and the column in bits [3:0]. A line end 0xN B goes to 0x(N+1)0, and 0x4B goes to 0x00.
- R7: With `dir_inc` low, an access strobe moves a valid address to the previous valid one. 0x(N+1)0 goes to 0xNB, and 0x00 goes to 0x4B.
- R8: A directly loaded invalid address is held exactly as loaded. The next step moves to the nearest valid address in the step direction. On an increment it wraps to 0x00 when there is none above. On a decrement it goes to 0x4B when there is none below.
- R9: In a cycle with `instr_we` high, the access strobe causes no step. With neither strobe high, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_we | input | 1 | Instruction write strobe, one clock |
| din | input | 8 | Instruction data byte |
| acc_stb | input | 1 | Data access strobe, one clock |
| dir_inc | input | 1 | Step direction: 1 increment, 0 decrement |
| sleep | input | 1 | Sleep mode flag |
| standby | input | 1 | Standby mode flag |
| addr | output | 7 | Address counter value |
| scan_int_en | output | 1 | Latched scan-interrupt enable |
| key_fmt | output | 2 | Latched key-format field |

## Verification
Every one of the 128 possible counter values is loaded through the two instruction bytes and then stepped once in each direction. A bench search over the valid-address set gives the expected result. This sweep separates plain in-line steps, line-end jumps, the two wrap points and the exits from every hole. Full walks of 60 steps in each direction show that each valid cell is visited once and the counter comes back to where it started. Separate cases cover undecoded bytes, writes during sleep or standby, and a strobe that coincides with a write. These show that such inputs leave the counter and the latches untouched, or that the instruction takes priority.

// File: rtl/ddram_addr_ctr.sv
module ddram_addr_ctr #(
  parameter int LINE_BITS = 3,
  parameter int COL_BITS  = 4,
  parameter int LINES     = 5,
  parameter int LINE_LEN  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          instr_we,
  input  logic [7:0]                    din,
  input  logic                          acc_stb,
  input  logic                          dir_inc,
  input  logic                          sleep,
  input  logic                          standby,
  output logic [LINE_BITS+COL_BITS-1:0] addr,
  output logic                          scan_int_en,
  output logic [1:0]                    key_fmt
);
  localparam int AW      = LINE_BITS + COL_BITS;
  localparam int LO_BITS = 5;
  localparam int HI_BITS = AW - LO_BITS;
  localparam logic [LINE_BITS-1:0] LAST_LINE = LINE_BITS'(LINES - 1);
  localparam logic [COL_BITS-1:0]  LAST_COL  = COL_BITS'(LINE_LEN - 1);
  localparam logic [AW-1:0]        LAST_ADDR = {LAST_LINE, LAST_COL};

  logic [LINE_BITS-1:0] line;
  logic [COL_BITS-1:0]  col;
  logic [AW-1:0]        nxt_inc, nxt_dec;
  logic                 set_ok, set_hi, set_lo;

  assign line   = addr[AW-1:COL_BITS];
  assign col    = addr[COL_BITS-1:0];
  assign set_ok = instr_we && !sleep && !standby;
  assign set_hi = set_ok && (din[7:5] == 3'b110);
  assign set_lo = set_ok && (din[7:5] == 3'b111);

  always_comb begin
    if (line > LAST_LINE || (line == LAST_LINE && col >= LAST_COL))
      nxt_inc = '0;
    else if (col >= LAST_COL)
      nxt_inc = {line + LINE_BITS'(1), COL_BITS'(0)};
    else
      nxt_inc = {line, col + COL_BITS'(1)};
  end

  always_comb begin
    if (line > LAST_LINE)
      nxt_dec = LAST_ADDR;
    else if (col > LAST_COL)
      nxt_dec = {line, LAST_COL};
    else if (col == '0)
      nxt_dec = (line == '0) ? LAST_ADDR : {line - LINE_BITS'(1), LAST_COL};
    else
      nxt_dec = {line, col - COL_BITS'(1)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr        <= '0;
      scan_int_en <= 1'b0;
      key_fmt     <= 2'b00;
    end else if (instr_we) begin
      if (set_hi) begin
        addr[AW-1:LO_BITS] <= din[HI_BITS-1:0];
        scan_int_en        <= din[4];
        key_fmt            <= din[3:2];
      end else if (set_lo) begin
        addr[LO_BITS-1:0] <= din[LO_BITS-1:0];
      end
    end else if (acc_stb) begin
      addr <= dir_inc ? nxt_inc : nxt_dec;
    end
  end
endmodule

// File: rtl/ddram_addr_ctr_chk.sv
module ddram_addr_ctr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_we,
  input logic [7:0] din,
  input logic       acc_stb,
  input logic       dir_inc,
  input logic       sleep,
  input logic       standby,
  input logic [6:0] addr,
  input logic       scan_int_en,
  input logic [1:0] key_fmt
);
  logic in_range;
  assign in_range = (addr[6:4] < 3'd5) && (addr[3:0] < 4'd12);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> addr == 7'd0 && !scan_int_en && key_fmt == 2'd0); // R1
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_we && !sleep && !standby && din[7:5] == 3'b110 |=>
    addr[6:5] == $past(din[1:0]) && addr[4:0] == $past(addr[4:0]) && scan_int_en == $past(din[4])); // R2
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_we && !sleep && !standby && din[7:5] == 3'b111 |=>
    addr[4:0] == $past(din[4:0]) && addr[6:5] == $past(addr[6:5]) && $stable(key_fmt)); // R3
  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_we && (sleep || standby) |=> $stable(addr) && $stable(scan_int_en) && $stable(key_fmt)); // R5
  AST_STEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !instr_we && in_range |=> in_range && addr != $past(addr)); // R6
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !instr_we && dir_inc && addr == 7'h4B |=> addr == 7'h00); // R6
  AST_BOTTOM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !instr_we && !dir_inc && addr == 7'h00 |=> addr == 7'h4B); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_we && !acc_stb |=> $stable(addr) && $stable(key_fmt)); // R9
endmodule

bind ddram_addr_ctr ddram_addr_ctr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .din(din), .acc_stb(acc_stb),
  .dir_inc(dir_inc), .sleep(sleep), .standby(standby), .addr(addr),
  .scan_int_en(scan_int_en), .key_fmt(key_fmt)
);

// File: tb/sim_ddram_addr_ctr.sv
module sim_ddram_addr_ctr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_we = 1'b0;
  logic [7:0] din = 8'h00;
  logic       acc_stb = 1'b0;
  logic       dir_inc = 1'b1;
  logic       sleep = 1'b0;
  logic       standby = 1'b0;
  logic [6:0] addr;
  logic       scan_int_en;
  logic [1:0] key_fmt;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddram_addr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .din(din), .acc_stb(acc_stb),
    .dir_inc(dir_inc), .sleep(sleep), .standby(standby), .addr(addr),
    .scan_int_en(scan_int_en), .key_fmt(key_fmt)
  );

  function automatic bit is_valid(int a);
    return ((a >> 4) < 5) && ((a & 15) < 12);
  endfunction

  function automatic int ref_inc(int a);
    for (int k = a + 1; k < 128; k++) if (is_valid(k)) return k;
    return 0;
  endfunction

  function automatic int ref_dec(int a);
    for (int k = a - 1; k >= 0; k--) if (is_valid(k)) return k;
    return 'h4B;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b, logic stb = 1'b0);
    @(negedge clk);
    instr_we = 1'b1; din = b; acc_stb = stb;
    @(negedge clk);
    instr_we = 1'b0; acc_stb = 1'b0;
  endtask

  task automatic step(logic up);
    @(negedge clk);
    acc_stb = 1'b1; dir_inc = up;
    @(negedge clk);
    acc_stb = 1'b0;
  endtask

  task automatic load(int a);
    wr({3'b110, 3'b000, 2'(a >> 5)});
    wr({3'b111, 5'(a)});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 addr", addr, 0);
    chk("R1 scan_int_en", scan_int_en, 0);
    chk("R1 key_fmt", key_fmt, 0);

    wr(8'b110_1_10_11);
    chk("R2 addr", addr, 'h60);
    chk("R2 scan_int_en", scan_int_en, 1);
    chk("R2 key_fmt", key_fmt, 2);
    wr(8'b111_00101);
    chk("R3 addr", addr, 'h65);
    chk("R3 key_fmt kept", key_fmt, 2);
    chk("R3 scan_int_en kept", scan_int_en, 1);
    wr(8'b110_0_01_00);
    chk("R2 low bits kept", addr, 'h05);
    chk("R2 key_fmt", key_fmt, 1);

    for (int b = 0; b < 6; b++) begin
      wr({3'(b), 5'b10110});
      chk("R4 addr", addr, 'h05);
      chk("R4 key_fmt", key_fmt, 1);
    end

    @(negedge clk); sleep = 1'b1;
    wr(8'b111_01010);
    chk("R5 sleep lower", addr, 'h05);
    wr(8'b110_1_11_10);
    chk("R5 sleep upper", addr, 'h05);
    chk("R5 sleep ctrl", key_fmt, 1);
    @(negedge clk); sleep = 1'b0; standby = 1'b1;
    wr(8'b110_1_11_10);
    chk("R5 standby upper", addr, 'h05);
    chk("R5 standby ctrl", scan_int_en, 0);
    wr(8'b111_01010);
    chk("R5 standby lower", addr, 'h05);
    @(negedge clk); standby = 1'b0;

    wr(8'b111_00011, 1'b1);
    chk("R9 write beats step", addr, 'h03);
    @(negedge clk); sleep = 1'b1;
    wr(8'b111_01000, 1'b1);
    chk("R9 blocked write still no step", addr, 'h03);
    @(negedge clk); sleep = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 idle hold", addr, 'h03);

    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        load(a);
        chk(is_valid(a) ? "R3 load" : "R8 invalid kept", addr, a);
        step(d[0]);
        if (!is_valid(a)) chk("R8 step from hole", addr, d ? ref_inc(a) : ref_dec(a));
        else if (d == 1) chk("R6 increment", addr, ref_inc(a));
        else chk("R7 decrement", addr, ref_dec(a));
      end
    end

    for (int d = 0; d < 2; d++) begin
      int prev;
      int seen;
      load(0);
      prev = 0; seen = 0;
      for (int n = 0; n < 60; n++) begin
        step(d[0]);
        if (addr != (d ? ref_inc(prev) : ref_dec(prev))) seen++;
        prev = addr;
      end
      chk(d ? "R6 walk mismatches" : "R7 walk mismatches", seen, 0);
      chk(d ? "R6 walk closes" : "R7 walk closes", addr, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule